// File: doc/BRIEF.md
# Boot-Time Configuration Loader over I2C

This block fills two system configuration words once per reset. While reset is held it samples two strap pins: one turns the serial loader on or off, the other picks which of two device addresses the serial memory answers on. The last sample taken before reset releases is kept. Changes on the pins after that have no effect, so the pins can go back to their normal use.

When the loader is on, the block acts as a simple single-master I2C controller. It writes word address 0x00 to the memory, sends a repeated START, and reads sixteen bytes in one sequential burst. The first four bytes form the first configuration word and the next four form the second. The other eight bytes are clocked in and thrown away. If the loader is off, or if any header byte is not acknowledged, both words take two default values set at build time. A one-cycle done pulse marks the point from which the words are valid. The words then hold until the next reset.

SCL and SDA are driven open-drain. An output of 1 pulls the line low, and the data line is read back through its own input. The SCL rate is a fixed division of the system clock, set from two parameters, with a default of 100 kHz.

Top module: `boot_cfg_loader`

## Requirements
- R1: Both straps are sampled on every clock edge while `rst_n` is low, and the value kept is the one from the last such edge. Strap changes after reset release change neither the address used nor whether the loader runs.
- R2: With `strap_boot_n` captured as 1 the loader is off. `scl_oe` and `sda_oe` stay 0 for the whole run, `cfg_err` stays 0, and at `cfg_done` the words equal the defaults `DFLT0` and `DFLT1`.
- R3: With `strap_addr_sel` captured as 0 the 7-bit device address is 0x54 (header bytes 0xA8 for write and 0xA9 for read). With 1 it is 0x50 (header bytes 0xA0 and 0xA1).
- R4: An enabled load runs as START, address with bit0=0, word address 0x00, repeated START, address with bit0=1, sixteen read bytes, STOP. That is exactly two START conditions and one STOP.
- R5: During the read burst the master acknowledges bytes 0 to 14 by holding SDA low in the ninth clock. It leaves SDA high in the ninth clock of byte 15.
- R6: `cfg_word0` is bytes 0..3 with byte 0 in bits 31:24. `cfg_word1` is bytes 4..7 with byte 4 in bits 31:24. Bytes 8..15 affect neither word.
- R7: If any of the three header bytes is not acknowledged, `cfg_err` goes to 1, no further byte is sent, a STOP follows, and both words take the defaults at `cfg_done`.
- R8: SDA changes while SCL is high only to form START and STOP, so a bus observer sees no condition beyond those listed in R4 or R7.
- R9: `cfg_done` is high for exactly one cycle and only once per reset. Both words read 0 before it and hold their value after it until the next reset.
- R10: While `rst_n` is low, on the cycle after any clock edge, `cfg_done`, `cfg_err`, both words, `scl_oe` and `sda_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_boot_n | input | 1 | Loader strap: 0 runs the serial load, 1 uses defaults |
| strap_addr_sel | input | 1 | Address strap: 0 selects 0x54, 1 selects 0x50 |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_in | input | 1 | Level read back from the SDA line |
| cfg_word0 | output | 32 | First configuration word |
| cfg_word1 | output | 32 | Second configuration word |
| cfg_done | output | 1 | One-cycle pulse when both words are valid |
| cfg_err | output | 1 | Set when a header byte was not acknowledged |

## Verification
The assertions assume the straps settle during reset and that `rst_n` is driven low from time zero. They also assume nothing but the memory model pulls SDA, and nothing stretches SCL. The bench drives straps and reset only at falling clock edges. Its memory model drives SDA only right after SCL falls and releases it on NACK or STOP. Line levels are formed as a wired-AND of the master and model pull-downs, so the engine always reads a level it could legally see on a real bus.

// File: rtl/bcl_pkg.sv
// Shared types for the boot configuration loader.
package bcl_pkg;
    // Bus-level operations issued by the sequencer to the bit engine.
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        SQ_BOOT  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_IDLE  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/bcl_strap_capture.sv
// Strap sampler: follows the pins on every edge while reset is low and
// freezes on release. Assumes the pins are settled at the last reset edge.
module bcl_strap_capture #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] q
);
    // Track pins during reset, hold afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= pins;
    end
endmodule

// File: rtl/bcl_qtick.sv
// Quarter-bit timer: pulses tick every QTR clocks while run is high.
// Assumes QTR >= 1; the count restarts whenever run drops.
module bcl_qtick #(
    parameter int QTR = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = (QTR > 1) ? $clog2(QTR) : 1;

    logic [W-1:0] cnt;

    assign tick = run && (cnt == W'(QTR - 1));

    // Count clocks within one quarter of an SCL period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bcl_bit_engine.sv
// I2C bit engine: runs one START, STOP, byte write or byte read per command.
// Each bit takes four quarter phases: SCL low (hold), SCL low (SDA set),
// SCL high, SCL high (SDA sampled on entry). START and STOP reuse the
// same frame and move SDA in the fourth phase. No clock stretching.
module bcl_bit_engine
    import bcl_pkg::*;
#(
    parameter int QTR = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  bus_op_e    cmd_op,
    input  logic [7:0] cmd_wdata,
    input  logic       cmd_mack,
    output logic       cmd_ready,
    output logic       cmd_done,
    output logic [7:0] rx_byte,
    output logic       rx_ack,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic       sda_in
);
    logic       active;
    logic [1:0] phase;
    logic [3:0] bitn;
    bus_op_e    op;
    logic [8:0] sh;
    logic [8:0] rx;
    logic       tick;

    bcl_qtick #(.QTR(QTR)) u_qtick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .tick (tick)
    );

    assign cmd_ready = !active;
    assign rx_byte   = rx[8:1];
    assign rx_ack    = !rx[0];

    // Accept a command, then step the phases and shift bits on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            phase    <= 2'd0;
            bitn     <= 4'd0;
            op       <= OP_START;
            sh       <= '1;
            rx       <= '0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            cmd_done <= 1'b0;
        end else begin
            cmd_done <= 1'b0;
            if (!active) begin
                if (cmd_valid) begin
                    active <= 1'b1;
                    op     <= cmd_op;
                    phase  <= 2'd0;
                    scl_oe <= 1'b1;
                    rx     <= '0;
                    bitn   <= (cmd_op == OP_WRITE || cmd_op == OP_READ) ? 4'd8 : 4'd0;
                    sh     <= (cmd_op == OP_WRITE) ? {cmd_wdata, 1'b1} : {8'hFF, !cmd_mack};
                end
            end else if (tick) begin
                phase <= phase + 2'd1;
                unique case (phase)
                    2'd0: begin
                        unique case (op)
                            OP_START: sda_oe <= 1'b0;
                            OP_STOP:  sda_oe <= 1'b1;
                            default:  sda_oe <= !sh[8];
                        endcase
                    end
                    2'd1: scl_oe <= 1'b0;
                    2'd2: begin
                        unique case (op)
                            OP_START: sda_oe <= 1'b1;
                            OP_STOP:  sda_oe <= 1'b0;
                            default:  rx     <= {rx[7:0], sda_in};
                        endcase
                    end
                    2'd3: begin
                        if (bitn != 4'd0) begin
                            bitn   <= bitn - 4'd1;
                            sh     <= {sh[7:0], 1'b1};
                            scl_oe <= 1'b1;
                        end else begin
                            active   <= 1'b0;
                            cmd_done <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/boot_cfg_loader.sv
// Boot configuration loader: captures straps during reset, then either
// loads defaults or reads a serial memory over I2C to fill two words.
// Assumes a single master on the bus and a memory that never stretches SCL.
module boot_cfg_loader
    import bcl_pkg::*;
#(
    parameter int                      CLK_HZ    = 100_000_000,
    parameter int                      SCL_HZ    = 100_000,
    parameter logic [6:0]              ADDR_SEL0 = 7'h54,
    parameter logic [6:0]              ADDR_SEL1 = 7'h50,
    parameter int                      RD_BYTES  = 16,
    parameter int                      CFG_BYTES = 4,
    parameter logic [8*CFG_BYTES-1:0]  DFLT0     = 32'h0000_0000,
    parameter logic [8*CFG_BYTES-1:0]  DFLT1     = 32'h0000_0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strap_boot_n,
    input  logic                     strap_addr_sel,
    output logic                     scl_oe,
    output logic                     sda_oe,
    input  logic                     sda_in,
    output logic [8*CFG_BYTES-1:0]   cfg_word0,
    output logic [8*CFG_BYTES-1:0]   cfg_word1,
    output logic                     cfg_done,
    output logic                     cfg_err
);
    localparam int CFG_W     = 8 * CFG_BYTES;
    localparam int QTR       = CLK_HZ / (4 * SCL_HZ);
    localparam int ST_RD0_I  = 5;
    localparam int ST_STOP_I = ST_RD0_I + RD_BYTES;
    localparam int SW        = $clog2(ST_STOP_I + 1);
    localparam logic [SW-1:0] ST_START1 = SW'(0);
    localparam logic [SW-1:0] ST_AW     = SW'(1);
    localparam logic [SW-1:0] ST_WA     = SW'(2);
    localparam logic [SW-1:0] ST_START2 = SW'(3);
    localparam logic [SW-1:0] ST_AR     = SW'(4);
    localparam logic [SW-1:0] ST_RDL    = SW'(ST_STOP_I - 1);
    localparam logic [SW-1:0] ST_STOP   = SW'(ST_STOP_I);

    logic [1:0]      straps_q;
    logic [6:0]      dev;
    seq_st_e         st;
    logic [SW-1:0]   step;
    bus_op_e         op;
    logic [7:0]      wdata;
    logic            mack;
    logic            cmd_valid, cmd_ready, cmd_done;
    logic [7:0]      rx_byte;
    logic            rx_ack;
    logic            hdr_step;
    int              rd_idx;
    logic [CFG_W-1:0] acc0, acc1;

    bcl_strap_capture #(.N(2)) u_strap (
        .clk  (clk),
        .rst_n(rst_n),
        .pins ({strap_boot_n, strap_addr_sel}),
        .q    (straps_q)
    );

    bcl_bit_engine #(.QTR(QTR)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (op),
        .cmd_wdata(wdata),
        .cmd_mack (mack),
        .cmd_ready(cmd_ready),
        .cmd_done (cmd_done),
        .rx_byte  (rx_byte),
        .rx_ack   (rx_ack),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .sda_in   (sda_in)
    );

    assign dev       = straps_q[0] ? ADDR_SEL1 : ADDR_SEL0;
    assign cmd_valid = (st == SQ_ISSUE);
    assign hdr_step  = (step == ST_AW) || (step == ST_WA) || (step == ST_AR);

    // Map the current step to a bus operation and its operand.
    always_comb begin
        rd_idx = int'(step) - ST_RD0_I;
        mack   = (step != ST_RDL);
        if (step == ST_START1 || step == ST_START2) op = OP_START;
        else if (step == ST_STOP)                   op = OP_STOP;
        else if (step < SW'(ST_RD0_I))              op = OP_WRITE;
        else                                        op = OP_READ;
        if (step == ST_AW)      wdata = {dev, 1'b0};
        else if (step == ST_AR) wdata = {dev, 1'b1};
        else                    wdata = 8'h00;
    end

    // Walk the load sequence, gather bytes and publish the words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_BOOT;
            step      <= ST_START1;
            cfg_err   <= 1'b0;
            cfg_done  <= 1'b0;
            acc0      <= '0;
            acc1      <= '0;
            cfg_word0 <= '0;
            cfg_word1 <= '0;
        end else begin
            cfg_done <= 1'b0;
            unique case (st)
                SQ_BOOT: begin
                    if (straps_q[1]) begin
                        cfg_word0 <= DFLT0;
                        cfg_word1 <= DFLT1;
                        cfg_done  <= 1'b1;
                        st        <= SQ_IDLE;
                    end else begin
                        st <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: if (cmd_ready) st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (cmd_done) begin
                        st   <= SQ_ISSUE;
                        step <= step + 1'b1;
                        if (hdr_step && !rx_ack) begin
                            cfg_err <= 1'b1;
                            step    <= ST_STOP;
                        end
                        if (op == OP_READ) begin
                            if (rd_idx < CFG_BYTES)
                                acc0 <= {acc0[CFG_W-9:0], rx_byte};
                            else if (rd_idx < 2 * CFG_BYTES)
                                acc1 <= {acc1[CFG_W-9:0], rx_byte};
                        end
                        if (step == ST_STOP) begin
                            st        <= SQ_IDLE;
                            cfg_done  <= 1'b1;
                            cfg_word0 <= cfg_err ? DFLT0 : acc0;
                            cfg_word1 <= cfg_err ? DFLT1 : acc1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bcl_checker.sv
// Property checker for boot_cfg_loader, attached by bind below.
// Assumes rst_n is low from time zero and straps settle during reset.
module bcl_checker #(
    parameter int              CFG_W = 32,
    parameter logic [CFG_W-1:0] DFLT0 = '0,
    parameter logic [CFG_W-1:0] DFLT1 = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strap_boot_n,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic [CFG_W-1:0] cfg_word0,
    input logic [CFG_W-1:0] cfg_word1,
    input logic             cfg_done,
    input logic             cfg_err
);
    logic off_seen;
    logic done_seen;

    // Remember the loader strap as seen at the end of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) off_seen <= strap_boot_n;
    end

    // Remember that the done pulse has already happened.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_seen <= 1'b0;
        else if (cfg_done) done_seen <= 1'b1;
    end

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!cfg_done && !cfg_err && !scl_oe && !sda_oe &&
                    cfg_word0 == '0 && cfg_word1 == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> !cfg_done);

    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |-> !cfg_done);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |-> ($stable(cfg_word0) && $stable(cfg_word1)));

    // R9
    pre_done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_seen && !cfg_done) |-> (cfg_word0 == '0 && cfg_word1 == '0));

    // R2
    boot_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_seen |-> (!scl_oe && !sda_oe));

    // R2
    boot_off_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && off_seen) |-> (cfg_word0 == DFLT0 && cfg_word1 == DFLT1 && !cfg_err));

    // R7
    err_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_err) |-> (cfg_word0 == DFLT0 && cfg_word1 == DFLT1));
endmodule

bind boot_cfg_loader bcl_checker #(
    .CFG_W(CFG_W),
    .DFLT0(DFLT0),
    .DFLT1(DFLT1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_boot_n(strap_boot_n),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe),
    .cfg_word0   (cfg_word0),
    .cfg_word1   (cfg_word1),
    .cfg_done    (cfg_done),
    .cfg_err     (cfg_err)
);

// File: tb/boot_cfg_loader_tb.sv
// Bench: behavioural serial-memory model on a wired-AND bus plus a
// per-clock reference of the expected outputs.
module boot_cfg_loader_tb;
    localparam logic [31:0] DF0 = 32'hC0FF_EE01;
    localparam logic [31:0] DF1 = 32'h1234_ABCD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_boot_n = 1'b0;
    logic        strap_addr_sel = 1'b0;
    logic        scl_oe, sda_oe, sda_in;
    logic [31:0] cfg_word0, cfg_word1;
    logic        cfg_done, cfg_err;
    logic        slv_drv = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = !clk;

    boot_cfg_loader #(
        .CLK_HZ(100_000_000), .SCL_HZ(5_000_000), .DFLT0(DF0), .DFLT1(DF1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_boot_n(strap_boot_n),
        .strap_addr_sel(strap_addr_sel), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_in(sda_in), .cfg_word0(cfg_word0), .cfg_word1(cfg_word1),
        .cfg_done(cfg_done), .cfg_err(cfg_err)
    );

    logic scl_ln, sda_ln;
    assign scl_ln = !scl_oe;
    assign sda_ln = !(sda_oe || slv_drv);
    assign sda_in = sda_ln;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model state
    logic [7:0] mem [16];
    logic [6:0] slv_addr;
    logic       nack_wa, nack_ar;
    int         n_start, n_stop, n_rise, rd_cnt, mode, bc, bidx;
    logic [7:0] sh;
    logic [3:0] ptr;
    logic       is_rd, prev_scl, prev_sda;
    logic [7:0] hdr_q[$];
    logic       mack_q[$];

    // Serial memory: follows the bus at falling clock edges.
    always @(negedge clk) begin
        if (!rst_n) begin
            mode = 0; bc = 0; bidx = 0; slv_drv = 1'b0; ptr = 4'd0; is_rd = 1'b0;
            n_start = 0; n_stop = 0; n_rise = 0; rd_cnt = 0; sh = 8'h00;
            hdr_q.delete(); mack_q.delete();
            prev_scl = 1'b1; prev_sda = 1'b1;
        end else begin
            logic s, d;
            s = scl_ln; d = sda_ln;
            if (prev_scl && s && prev_sda && !d) begin
                n_start++; mode = 1; bc = 0; bidx = 0; slv_drv = 1'b0;
            end else if (prev_scl && s && !prev_sda && d) begin
                n_stop++; mode = 0; slv_drv = 1'b0;
            end else if (!prev_scl && s) begin
                n_rise++;
                if (mode == 1) begin sh = {sh[6:0], d}; bc++; end
                else if (mode == 3) bc++;
                else if (mode == 4) mack_q.push_back(!d);
            end else if (prev_scl && !s) begin
                if (mode == 1 && bc == 8) begin
                    logic ok;
                    hdr_q.push_back(sh);
                    if (bidx == 0) begin
                        is_rd = sh[0];
                        ok = (sh[7:1] == slv_addr) && !(is_rd && nack_ar);
                    end else begin
                        ok = !nack_wa;
                        ptr = sh[3:0];
                    end
                    if (ok) begin slv_drv = 1'b1; mode = 2; end
                    else mode = 0;
                end else if (mode == 2) begin
                    slv_drv = 1'b0; bidx++; bc = 0;
                    if (is_rd) begin mode = 3; slv_drv = !mem[ptr][7]; end
                    else mode = 1;
                end else if (mode == 3) begin
                    if (bc == 8) begin slv_drv = 1'b0; mode = 4; rd_cnt++; end
                    else slv_drv = !mem[ptr][7 - bc];
                end else if (mode == 4) begin
                    if (mack_q.size() > 0 && mack_q[$]) begin
                        ptr = ptr + 4'd1; mode = 3; bc = 0; slv_drv = !mem[ptr][7];
                    end else mode = 0;
                end
            end
            prev_scl = s; prev_sda = d;
        end
    end

    // Reference outputs compared every clock.
    logic [31:0] exp0, exp1;
    logic        exp_err;
    logic        seen;
    int          n_done;

    always @(negedge clk) begin
        if (!rst_n) begin
            seen = 1'b0; n_done = 0;
        end else begin
            if (cfg_done) begin
                n_done++;
                check("R9 single done", {63'd0, seen}, 64'd0);
                check("R6/R2/R7 word0 at done", {32'd0, cfg_word0}, {32'd0, exp0});
                check("R6/R2/R7 word1 at done", {32'd0, cfg_word1}, {32'd0, exp1});
                check("R7 err at done", {63'd0, cfg_err}, {63'd0, exp_err});
                seen = 1'b1;
            end else if (seen) begin
                check("R9 hold word0", {32'd0, cfg_word0}, {32'd0, exp0});
                check("R9 hold word1", {32'd0, cfg_word1}, {32'd0, exp1});
            end else begin
                check("R9 zero before done", {cfg_word0, cfg_word1}, 64'd0);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190_000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run_case(input logic early_off, input logic early_sel,
                            input logic off, input logic sel,
                            input logic [6:0] saddr, input logic nwa, input logic nar,
                            input int seed, input int exp_hdr, input logic err);
        logic [6:0] dev;
        @(negedge clk);
        rst_n = 1'b0;
        strap_boot_n = early_off; strap_addr_sel = early_sel;
        slv_addr = saddr; nack_wa = nwa; nack_ar = nar;
        for (int i = 0; i < 16; i++) mem[i] = 8'(seed * 7 + i * 29 + (i << 4));
        dev = sel ? 7'h50 : 7'h54;
        exp_err = err;
        if (off || err) begin exp0 = DF0; exp1 = DF1; end
        else begin
            exp0 = {mem[0], mem[1], mem[2], mem[3]};
            exp1 = {mem[4], mem[5], mem[6], mem[7]};
        end
        repeat (4) @(negedge clk);
        strap_boot_n = off; strap_addr_sel = sel;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset outputs", {cfg_done, cfg_err, scl_oe, sda_oe, cfg_word0 | cfg_word1}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: straps ignored after release
        strap_boot_n = !off; strap_addr_sel = !sel;
        for (int w = 0; w < 20_000 && n_done == 0; w++) @(negedge clk);
        repeat (200) @(negedge clk);
        check("R9 one done pulse", 64'(n_done), 64'd1);
        if (off) begin
            check("R2 no SCL activity", 64'(n_rise), 64'd0);
            check("R2 no START", 64'(n_start), 64'd0);
        end else begin
            check("R1/R3 first header byte", 64'(hdr_q.size() > 0 ? hdr_q[0] : 8'hEE),
                  64'({dev, 1'b0}));
            check("R4/R7 header count", 64'(hdr_q.size()), 64'(exp_hdr));
            if (exp_hdr > 1) check("R4 word address", 64'(hdr_q[1]), 64'h00);
            if (exp_hdr > 2) check("R3 read header", 64'(hdr_q[2]), 64'({dev, 1'b1}));
            check("R8/R4 START count", 64'(n_start), 64'(exp_hdr > 2 ? 2 : 1));
            check("R8/R4/R7 STOP count", 64'(n_stop), 64'd1);
            if (!err) begin
                check("R4 bytes read", 64'(rd_cnt), 64'd16);
                check("R5 ack count", 64'(mack_q.size()), 64'd16);
                for (int k = 0; k < 16 && k < mack_q.size(); k++)
                    check(k == 15 ? "R5 final NACK" : "R5 ACK", 64'(mack_q[k]), 64'(k != 15));
            end else begin
                check("R7 no data after NACK", 64'(rd_cnt), 64'd0);
            end
        end
    endtask

    initial begin
        exp0 = '0; exp1 = '0; exp_err = 1'b0; slv_addr = 7'h54;
        nack_wa = 1'b0; nack_ar = 1'b0;
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R3/R6 address 0x54, normal load
        run_case(1'b1, 1'b1, 1'b0, 1'b0, 7'h54, 1'b0, 1'b0, 3, 3, 1'b0);
        // R1 late strap change in reset selects 0x50 and enables
        run_case(1'b1, 1'b0, 1'b0, 1'b1, 7'h50, 1'b0, 1'b0, 11, 3, 1'b0);
        // R2 loader off
        run_case(1'b0, 1'b0, 1'b1, 1'b0, 7'h54, 1'b0, 1'b0, 5, 0, 1'b0);
        // R7 address NACK (memory answers on the other address)
        run_case(1'b0, 1'b0, 1'b0, 1'b0, 7'h50, 1'b0, 1'b0, 7, 1, 1'b1);
        // R7 word address NACK
        run_case(1'b0, 1'b0, 1'b0, 1'b1, 7'h50, 1'b1, 1'b0, 9, 2, 1'b1);
        // R7 read header NACK
        run_case(1'b0, 1'b0, 1'b0, 1'b0, 7'h54, 1'b0, 1'b1, 13, 3, 1'b1);
        // R6 second pattern on 0x50
        run_case(1'b0, 1'b0, 1'b0, 1'b1, 7'h50, 1'b0, 1'b0, 21, 3, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule